// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for a short, fixed-length burst. When either of two burst-start strobes is high on a clock edge, it captures a full starting address. It also latches which burst order to use. On each later cycle where the active-low advance input is low, only the low beat bits of the address move to the next beat. When advance is high, the address stays where it is, which suspends the burst.

Two orderings are offered. In linear order the low bits count upward from the start and wrap modulo the burst length. In interleaved order the low bits are the start value XORed with a beat count. After the last beat, one more advance returns the address to the start, and the pattern repeats.

The upper address bits are captured with the start and do not change until the next load. A typical use is driving the row and column address of a synchronous memory during cache-line fills. Memory access, data paths and chip-select decoding are handled outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: When `start_a_i` or `start_b_i` is high at a rising clock edge, `addr_o` equals the `addr_i` sampled at that edge from that edge on.
- R2: With order 0 (linear) latched, after k advances since the load the low `BEAT_W` bits of `addr_o` equal (start + k) modulo 2^BEAT_W. For example, a start of 2'b10 gives 10, 11, 00, 01.
- R3: With order 1 (interleaved) latched, after k advances the low bits equal start XOR k. For example, a start of 2'b01 gives 01, 00, 11, 10.
- R4: The address steps only at edges where `adv_n_i` is low. With `adv_n_i` high and no strobe, `addr_o` is unchanged.
- R5: A strobe takes precedence over advance. A load edge with `adv_n_i` low yields the new start, not a stepped address.
- R6: After 2^BEAT_W advances (four by default), `addr_o` is back at the loaded start address, and the sequence then repeats.
- R7: Bits above the low `BEAT_W` keep their loaded value for as long as no new load occurs.
- R8: `order_i` is sampled only at a load edge. Changing it in the middle of a burst does not alter the sequence.
- R9: A synchronous active-high `rst` clears `addr_o` to zero, the beat count to zero and the order to linear. An advance after reset then counts 1, 2, 3 on the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_a_i | input | 1 | Burst-start strobe, first source |
| start_b_i | input | 1 | Burst-start strobe, second source |
| adv_n_i | input | 1 | Advance, active low; high suspends |
| order_i | input | 1 | 0 linear, 1 interleaved; sampled at load |
| addr_i | input | ADDR_W | Starting address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
On every cycle the assertions check several properties:
- a load is honoured, including when it collides with advance;
- the address holds on suspend;
- the upper bits stay frozen;
- the latched order never changes between loads;
- each advance moves the beat offset by exactly one, in the latched order.

Only the bench scenarios can show the full-burst properties. These include the wrap back to the start after four advances, the concrete example sequences for both orders, and that a mode change mid-burst has no effect on the observed addresses. The bench's reference model compares the full address every cycle under directed and random strobe, advance and mode traffic.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              inc,
   output logic [BEAT_W-1:0] cnt
);

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= cnt + ONE;
      end
   end

endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     order_i,
   output logic [ADDR_W-BEAT_W-1:0] upper_q,
   output logic [BEAT_W-1:0]        start_q,
   output burst_order_e             order_q
);

   localparam int UP_W = ADDR_W - BEAT_W;

   always_ff @(posedge clk) begin
      if (rst) begin
         upper_q <= '0;
         start_q <= '0;
         order_q <= ORD_LINEAR;
      end else if (load) begin
         upper_q <= addr_i[ADDR_W-1:BEAT_W];
         start_q <= addr_i[BEAT_W-1:0];
         order_q <= burst_order_e'(order_i);
      end
   end

   generate
      if (UP_W < 1) begin : g_bad_width
         $error("burst_start_reg: ADDR_W must exceed BEAT_W");
      end
   endgenerate

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start,
   input  logic [BEAT_W-1:0] cnt,
   input  burst_order_e      order,
   output logic [BEAT_W-1:0] low
);

   logic [BEAT_W-1:0] lin_low;
   logic [BEAT_W-1:0] ilv_low;

   assign lin_low = start + cnt;

   generate
      for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
         assign ilv_low[b] = start[b] ^ cnt[b];
      end
   endgenerate

   always_comb begin
      unique case (order)
         ORD_LINEAR:     low = lin_low;
         ORD_INTERLEAVE: low = ilv_low;
         default:        low = lin_low;
      endcase
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_a_i,
   input  logic              start_b_i,
   input  logic              adv_n_i,
   input  logic              order_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int UP_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1 || BEAT_W > 8) begin : g_bad_beat
         $error("burst_addr_seq: BEAT_W out of range 1..8");
      end
      if (ADDR_W <= BEAT_W) begin : g_bad_addr
         $error("burst_addr_seq: ADDR_W must exceed BEAT_W");
      end
   endgenerate

   logic              load;
   logic              step;
   logic [BEAT_W-1:0] beat_cnt;
   logic [UP_W-1:0]   upper_q;
   logic [BEAT_W-1:0] start_q;
   burst_order_e      order_q;
   logic [BEAT_W-1:0] low_bits;

   // a strobe always wins over advance
   assign load = start_a_i | start_b_i;
   assign step = ~adv_n_i & ~load;

   burst_start_reg #(
      .ADDR_W (ADDR_W),
      .BEAT_W (BEAT_W)
   ) u_start (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .addr_i  (addr_i),
      .order_i (order_i),
      .upper_q (upper_q),
      .start_q (start_q),
      .order_q (order_q)
   );

   burst_beat_ctr #(
      .BEAT_W (BEAT_W)
   ) u_ctr (
      .clk (clk),
      .rst (rst),
      .clr (load),
      .inc (step),
      .cnt (beat_cnt)
   );

   burst_order_map #(
      .BEAT_W (BEAT_W)
   ) u_map (
      .start (start_q),
      .cnt   (beat_cnt),
      .order (order_q),
      .low   (low_bits)
   );

   assign addr_o = {upper_q, low_bits};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              start_a_i,
   input logic              start_b_i,
   input logic              adv_n_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [BEAT_W-1:0] start_q,
   input burst_order_e      order_q
);

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   logic              ld;
   logic              adv;
   logic [BEAT_W-1:0] rel_lin;
   logic [BEAT_W-1:0] rel_ilv;

   assign ld      = start_a_i | start_b_i;
   assign adv     = ~adv_n_i & ~ld;
   assign rel_lin = addr_o[BEAT_W-1:0] - start_q;
   assign rel_ilv = addr_o[BEAT_W-1:0] ^ start_q;

   // R1
   load_take_chk: assert property (@(posedge clk) disable iff (rst)
      ld |=> addr_o == $past(addr_i));

   // R5
   load_over_adv_chk: assert property (@(posedge clk) disable iff (rst)
      (ld && !adv_n_i) |=> addr_o == $past(addr_i));

   // R2
   lin_step_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && order_q == ORD_LINEAR) |=> rel_lin == $past(rel_lin) + ONE);

   // R3
   ilv_step_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && order_q == ORD_INTERLEAVE) |=> rel_ilv == $past(rel_ilv) + ONE);

   // R4
   suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ld && adv_n_i) |=> $stable(addr_o));

   // R7
   upper_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

   // R8
   order_locked_chk: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(order_q));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> addr_o == '0);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
   .ADDR_W (ADDR_W),
   .BEAT_W (BEAT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start_a_i (start_a_i),
   .start_b_i (start_b_i),
   .adv_n_i   (adv_n_i),
   .addr_i    (addr_i),
   .addr_o    (addr_o),
   .start_q   (start_q),
   .order_q   (order_q)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sa = 1'b0;
   logic          sb = 1'b0;
   logic          advn = 1'b1;
   logic          ord = 1'b0;
   logic [AW-1:0] ain = '0;
   logic [AW-1:0] aout;

   int n_chk = 0;
   int n_err = 0;

   // reference model state
   int m_upper = 0;
   int m_start = 0;
   int m_cnt   = 0;
   int m_ord   = 0;

   always #2.5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) i_burst_addr_seq (
      .clk       (clk),
      .rst       (rst),
      .start_a_i (sa),
      .start_b_i (sb),
      .adv_n_i   (advn),
      .order_i   (ord),
      .addr_i    (ain),
      .addr_o    (aout)
   );

   function automatic int model_addr();
      int low;
      if (m_ord != 0) low = m_start ^ m_cnt;
      else            low = (m_start + m_cnt) % 4;
      return (m_upper << 2) | low;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic a, input logic b, input logic an,
                       input logic o, input logic [AW-1:0] ad, input string tag);
      @(negedge clk);
      sa = a; sb = b; advn = an; ord = o; ain = ad;
      if (a || b) begin
         m_upper = int'(ad) >> 2;
         m_start = int'(ad) & 3;
         m_cnt   = 0;
         m_ord   = int'(o);
      end else if (!an) begin
         m_cnt = (m_cnt + 1) % 4;
      end
      @(posedge clk);
      #1;
      check(tag, int'(aout), model_addr());
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; sa = 0; sb = 0; advn = 1; ord = 0;
      m_upper = 0; m_start = 0; m_cnt = 0; m_ord = 0;
      @(posedge clk);
      #1;
      check("R9 reset", int'(aout), 0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      do_reset();

      // R9: linear count from zero after reset
      step(0, 0, 0, 1, 16'h0000, "R9 adv after reset");
      check("R9 low=1", int'(aout[1:0]), 1);
      step(0, 0, 0, 1, 16'h0000, "R9 adv after reset");
      check("R9 low=2", int'(aout[1:0]), 2);

      // R2 linear from 10, literal sequence, then R6 wrap
      step(1, 0, 1, 0, 16'hABCE, "R1 load a");
      check("R1 load value", int'(aout), 16'hABCE);
      step(0, 0, 0, 0, 16'h0000, "R2 linear");
      check("R2 low 11", int'(aout[1:0]), 3);
      step(0, 0, 0, 0, 16'h0000, "R2 linear");
      check("R2 low 00", int'(aout[1:0]), 0);
      step(0, 0, 0, 0, 16'h0000, "R2 linear");
      check("R2 low 01", int'(aout[1:0]), 1);
      step(0, 0, 0, 0, 16'h0000, "R6 wrap");
      check("R6 back to start", int'(aout), 16'hABCE);
      check("R7 upper kept", int'(aout[15:2]), 16'hABCE >> 2);

      // R3 interleave from 01 via strobe b, with R4 suspend in the middle
      step(0, 1, 1, 1, 16'h1235, "R1 load b");
      step(0, 0, 0, 0, 16'hFFFF, "R3 interleave");
      check("R3 low 00", int'(aout[1:0]), 0);
      step(0, 0, 1, 0, 16'hFFFF, "R4 suspend");
      check("R4 held", int'(aout[1:0]), 0);
      step(0, 0, 1, 1, 16'h0000, "R4 suspend");
      step(0, 0, 0, 0, 16'h0000, "R3 interleave");
      check("R3 low 11", int'(aout[1:0]), 3);
      step(0, 0, 0, 1, 16'h0000, "R3 interleave");
      check("R3 low 10", int'(aout[1:0]), 2);
      step(0, 0, 0, 0, 16'h0000, "R6 wrap");
      check("R6 interleave wrap", int'(aout), 16'h1235);

      // R5: load with advance low gives the new start
      step(0, 0, 0, 0, 16'h0000, "R4 step");
      step(1, 1, 0, 0, 16'h5677, "R5 load beats adv");
      check("R5 exact start", int'(aout), 16'h5677);

      // R8: order flipped mid-burst has no effect (linear from 11)
      step(0, 0, 0, 1, 16'h0000, "R8 order ignored");
      check("R8 low 00", int'(aout[1:0]), 0);
      step(0, 0, 0, 1, 16'h0000, "R8 order ignored");
      check("R8 low 01", int'(aout[1:0]), 1);

      // R9 reset mid-burst
      do_reset();

      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         logic a, b, an, o;
         logic [AW-1:0] ad;
         a  = ($urandom % 6) == 0;
         b  = ($urandom % 8) == 0;
         an = ($urandom % 3) == 0;
         o  = 1'($urandom);
         ad = AW'($urandom);
         if (a || b)   step(a, b, an, o, ad, "R1 rand load");
         else if (!an) step(a, b, an, o, ad, "R2/R3 rand adv");
         else          step(a, b, an, o, ad, "R4 rand hold");
      end

      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule